// File: doc/BRIEF.md
# Double-Indexed Address Walker

This block produces the read-address sequence for one DMA block. It is loaded with a start address, an element size, an element count per frame, a frame count, and two signed strides. The first stride is applied between elements and the second at frame boundaries. After loading, it issues one address per accepted beat on a ready/valid output. It marks the final element of every frame and the final element of the block. Because the strides are signed, the block can scan memory backwards or across columns. This supports rotated or mirrored picture reads.

In double-indexed mode, the step after an element inside a frame is (element bytes − 1 + element stride). The step after the last element of a frame is (element bytes − 1 + frame stride). With double indexing off, the address advances by the element size on every beat and both strides are ignored. The block moves no data. It only walks addresses, and a downstream reader consumes the ready/valid stream.

Top module: `addr_walker`

## Requirements
- R1: The 2-bit size code selects the element size: code 0 is 1 byte, code 1 is 2 bytes, and codes 2 and 3 are 4 bytes.
- R2: A start pulse while idle loads the configuration. On the next cycle busy and addr_valid are high and addr_out equals the loaded start address exactly.
- R3: In double-indexed mode, after an accepted beat that is not the last of its frame, the next address is the previous address + bytes − 1 + the 16-bit element stride (sign-extended), modulo 2^32.
- R4: In double-indexed mode, after an accepted beat that is the last of its frame, the next address is the previous address + bytes − 1 + the 32-bit frame stride (signed), modulo 2^32.
- R5: With double indexing off, every step is + bytes, whatever the stride inputs hold.
- R6: last_elem is high exactly on the address that is the final element of a frame.
- R7: last_block is high exactly on the final address of the block (which also carries last_elem). The cycle after that beat is accepted, busy and addr_valid are low.
- R8: While addr_valid is high and addr_ready is low, addr_out holds its value and addr_valid stays high.
- R9: A start pulse while busy is ignored: the running sequence and its length are unchanged.
- R10: An element count or frame count of zero is treated as one.
- R11: Reset, synchronous and active high, leaves busy and addr_valid low, including when it is applied in the middle of a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load configuration and begin a block (idle only) |
| start_addr | input | AW | First address of the block |
| size_code | input | 2 | Element size code |
| dbl_mode | input | 1 | 1 = double-indexed stepping, 0 = plain increment |
| elem_count | input | CW | Elements per frame |
| frame_count | input | CW | Frames per block |
| elem_step | input | EIW | Signed element stride |
| frame_step | input | FIW | Signed frame stride |
| busy | output | 1 | A block is in progress |
| addr_valid | output | 1 | addr_out holds an address to be taken |
| addr_ready | input | 1 | Consumer accepts the address this cycle |
| addr_out | output | AW | Current read address |
| last_elem | output | 1 | Address is the last element of its frame |
| last_block | output | 1 | Address is the last of the block |

## Verification
The frame-boundary step and the end of the block can fall on the same accepted beat. On that beat the final element of the last frame must raise last_elem and last_block together, and the walker must stop rather than apply the frame stride. This is provoked by vectors with one element per frame, a single frame, and zero counts, under both continuous and throttled ready. It is judged by the bench's flag checks on that beat and by a check that busy and valid are low one cycle later. A start pulse injected mid-block is also made to coincide with an accepted beat, and the bench checks that the sequence continues unchanged.

// File: rtl/aw_pkg.sv
package aw_pkg;

    localparam int ADDR_W_DEF = 32;
    localparam int CNT_W_DEF  = 16;
    localparam int EIDX_W_DEF = 16;
    localparam int FIDX_W_DEF = 32;

    typedef enum logic [1:0] {
        SZ_BYTE     = 2'd0,
        SZ_HALF     = 2'd1,
        SZ_WORD     = 2'd2,
        SZ_WORD_ALT = 2'd3
    } size_code_e;

    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_RUN  = 1'b1
    } walk_state_e;

    function automatic logic [2:0] elem_bytes(input logic [1:0] code);
        logic [2:0] b;
        case (size_code_e'(code))
            SZ_BYTE: b = 3'd1;
            SZ_HALF: b = 3'd2;
            default: b = 3'd4;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/aw_step.sv
module aw_step #(
    parameter int AW  = 32,
    parameter int EIW = 16,
    parameter int FIW = 32
) (
    input  logic [2:0]     es,
    input  logic           dbl,
    input  logic           frame_end,
    input  logic [EIW-1:0] ei,
    input  logic [FIW-1:0] fi,
    output logic [AW-1:0]  step
);
    logic [AW-1:0] ei_x;
    logic [AW-1:0] fi_x;
    logic [AW-1:0] es_x;

    generate
        if (EIW < AW) begin : g_ei_ext
            assign ei_x = {{(AW-EIW){ei[EIW-1]}}, ei};
        end else begin : g_ei_cut
            assign ei_x = ei[AW-1:0];
        end
        if (FIW < AW) begin : g_fi_ext
            assign fi_x = {{(AW-FIW){fi[FIW-1]}}, fi};
        end else begin : g_fi_cut
            assign fi_x = fi[AW-1:0];
        end
    endgenerate

    assign es_x = {{(AW-3){1'b0}}, es};

    always_comb begin
        if (dbl) begin
            step = es_x - {{(AW-1){1'b0}}, 1'b1} + (frame_end ? fi_x : ei_x);
        end else begin
            step = es_x;
        end
    end
endmodule

// File: rtl/aw_count.sv
module aw_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          adv,
    input  logic [CW-1:0] ne,
    input  logic [CW-1:0] nf,
    output logic          frame_end,
    output logic          block_end
);
    typedef struct packed {
        logic [CW-1:0] epos;
        logic [CW-1:0] fpos;
        logic [CW-1:0] elim;
        logic [CW-1:0] flim;
    } pos_t;

    pos_t pos_q;

    function automatic logic [CW-1:0] limit_of(input logic [CW-1:0] n);
        return (n == '0) ? '0 : n - {{(CW-1){1'b0}}, 1'b1};
    endfunction

    assign frame_end = (pos_q.epos == pos_q.elim);
    assign block_end = frame_end && (pos_q.fpos == pos_q.flim);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (load) begin
            pos_q.epos <= '0;
            pos_q.fpos <= '0;
            pos_q.elim <= limit_of(ne);
            pos_q.flim <= limit_of(nf);
        end else if (adv) begin
            if (frame_end) begin
                pos_q.epos <= '0;
                pos_q.fpos <= pos_q.fpos + {{(CW-1){1'b0}}, 1'b1};
            end else begin
                pos_q.epos <= pos_q.epos + {{(CW-1){1'b0}}, 1'b1};
            end
        end
    end
endmodule

// File: rtl/addr_walker.sv
module addr_walker #(
    parameter int AW  = aw_pkg::ADDR_W_DEF,
    parameter int CW  = aw_pkg::CNT_W_DEF,
    parameter int EIW = aw_pkg::EIDX_W_DEF,
    parameter int FIW = aw_pkg::FIDX_W_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [AW-1:0]  start_addr,
    input  logic [1:0]     size_code,
    input  logic           dbl_mode,
    input  logic [CW-1:0]  elem_count,
    input  logic [CW-1:0]  frame_count,
    input  logic [EIW-1:0] elem_step,
    input  logic [FIW-1:0] frame_step,
    output logic           busy,
    output logic           addr_valid,
    input  logic           addr_ready,
    output logic [AW-1:0]  addr_out,
    output logic           last_elem,
    output logic           last_block
);
    import aw_pkg::*;

    typedef struct packed {
        logic [2:0]     es;
        logic           dbl;
        logic [EIW-1:0] ei;
        logic [FIW-1:0] fi;
    } cfg_t;

    walk_state_e   state_q;
    cfg_t          cfg_q;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] step;
    logic          accept;
    logic          fire;
    logic          frame_end;
    logic          block_end;
    logic [2:0]    es_q;
    logic          dbl_q;

    assign busy   = (state_q == WALK_RUN);
    assign accept = !busy && start;
    assign fire   = busy && addr_ready;
    assign es_q   = cfg_q.es;
    assign dbl_q  = cfg_q.dbl;

    aw_count #(.CW(CW)) u_count (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .adv       (fire),
        .ne        (elem_count),
        .nf        (frame_count),
        .frame_end (frame_end),
        .block_end (block_end)
    );

    aw_step #(.AW(AW), .EIW(EIW), .FIW(FIW)) u_step (
        .es        (cfg_q.es),
        .dbl       (cfg_q.dbl),
        .frame_end (frame_end),
        .ei        (cfg_q.ei),
        .fi        (cfg_q.fi),
        .step      (step)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WALK_IDLE;
            cfg_q   <= '0;
            addr_q  <= '0;
        end else if (accept) begin
            state_q   <= WALK_RUN;
            cfg_q.es  <= elem_bytes(size_code);
            cfg_q.dbl <= dbl_mode;
            cfg_q.ei  <= elem_step;
            cfg_q.fi  <= frame_step;
            addr_q    <= start_addr;
        end else if (fire) begin
            if (block_end) begin
                state_q <= WALK_IDLE;
            end else begin
                addr_q <= addr_q + step;
            end
        end
    end

    assign addr_valid = busy;
    assign addr_out   = addr_q;
    assign last_elem  = busy && frame_end;
    assign last_block = busy && block_end;
endmodule

// File: rtl/aw_checker.sv
module aw_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [AW-1:0] start_addr,
    input logic          busy,
    input logic          addr_valid,
    input logic          addr_ready,
    input logic [AW-1:0] addr_out,
    input logic          last_elem,
    input logic          last_block,
    input logic [2:0]    es,
    input logic          dbl
);
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr_out)));

    assert_first_addr_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (addr_valid && addr_out == $past(start_addr)));

    assert_stop_after_last_R7: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && addr_ready && last_block) |=> (!busy && !addr_valid));

    assert_block_implies_frame_R6: assert property (@(posedge clk) disable iff (rst)
        last_block |-> last_elem);

    assert_plain_step_R5: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && addr_ready && !last_block && !dbl)
        |=> (addr_out == $past(addr_out) + {{(AW-3){1'b0}}, $past(es)}));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !(addr_ready && last_block)) |=> busy);
endmodule

bind addr_walker aw_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_addr (start_addr),
    .busy       (busy),
    .addr_valid (addr_valid),
    .addr_ready (addr_ready),
    .addr_out   (addr_out),
    .last_elem  (last_elem),
    .last_block (last_block),
    .es         (es_q),
    .dbl        (dbl_q)
);

// File: tb/addr_walker_bench.sv
`timescale 1ns/1ps
module addr_walker_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] start_addr;
    logic [1:0]  size_code;
    logic        dbl_mode;
    logic [15:0] elem_count;
    logic [15:0] frame_count;
    logic [15:0] elem_step;
    logic [31:0] frame_step;
    logic        busy;
    logic        addr_valid;
    logic        addr_ready;
    logic [31:0] addr_out;
    logic        last_elem;
    logic        last_block;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    addr_walker u_addr_walker (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .size_code(size_code), .dbl_mode(dbl_mode), .elem_count(elem_count),
        .frame_count(frame_count), .elem_step(elem_step), .frame_step(frame_step),
        .busy(busy), .addr_valid(addr_valid), .addr_ready(addr_ready),
        .addr_out(addr_out), .last_elem(last_elem), .last_block(last_block)
    );

    typedef struct packed {
        logic [31:0] base;
        logic [1:0]  code;
        logic [15:0] ne;
        logic [15:0] nf;
        logic [15:0] ei;
        logic [31:0] fi;
        logic        dbl;
        logic        slow;
        logic        poke;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VEC [NVEC] = '{
        '{32'h0000_1000, 2'd1, 16'd4, 16'd3, 16'd1,      32'd1,          1'b1, 1'b0, 1'b0},
        '{32'h0000_2000, 2'd2, 16'd3, 16'd2, 16'hFFF9,   32'd13,         1'b1, 1'b1, 1'b0},
        '{32'h0000_3000, 2'd0, 16'd5, 16'd2, 16'd100,    32'hFFFF_FFCE,  1'b0, 1'b0, 1'b1},
        '{32'hFFFF_FFF0, 2'd2, 16'd2, 16'd2, 16'h7FFF,   32'h8000_0000,  1'b1, 1'b1, 1'b0},
        '{32'h0000_4000, 2'd1, 16'd0, 16'd0, 16'd5,      32'd5,          1'b1, 1'b0, 1'b0},
        '{32'h0000_5000, 2'd3, 16'd1, 16'd3, 16'd9,      32'hFFFF_FFEC,  1'b0, 1'b1, 1'b1},
        '{32'h0000_6000, 2'd0, 16'd4, 16'd2, 16'hFFFF,   32'd9,          1'b1, 1'b1, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] bytes_of(input logic [1:0] c);
        return (c == 2'd0) ? 32'd1 : (c == 2'd1) ? 32'd2 : 32'd4;
    endfunction

    task automatic run_vec(input vec_t v);
        int ne_eff = (v.ne == 0) ? 1 : int'(v.ne);
        int nf_eff = (v.nf == 0) ? 1 : int'(v.nf);
        int beats  = ne_eff * nf_eff;
        int k = 0, e = 0, f = 0, cyc = 0;
        logic [31:0] es = bytes_of(v.code);
        logic [31:0] m  = v.base;
        logic [31:0] hold_a = '0;
        bit hold_v = 0;
        bit rdy;
        bit le_exp, lb_exp;
        string tag = "R2";
        string lt  = (v.ne == 0 || v.nf == 0) ? "R7 R10" : "R7";
        @(negedge clk);
        start = 1'b1; start_addr = v.base; size_code = v.code; dbl_mode = v.dbl;
        elem_count = v.ne; frame_count = v.nf; elem_step = v.ei; frame_step = v.fi;
        @(negedge clk);
        start = 1'b0; start_addr = 32'h0; elem_step = 16'h1234; frame_step = 32'h5555;
        dbl_mode = ~v.dbl; size_code = ~v.code;
        chk(busy && addr_valid, "R2 busy", {30'b0, busy, addr_valid}, 32'h3);
        while (k < beats && cyc < 3000) begin
            if (hold_v) chk(addr_valid && addr_out == hold_a, "R8", addr_out, hold_a);
            rdy = v.slow ? (cyc % 3 == 2) : 1'b1;
            addr_ready = rdy;
            if (v.poke && (cyc == 3 || cyc == 4)) begin
                start = 1'b1; start_addr = 32'hDEAD_0000; elem_count = 16'd50; frame_count = 16'd50;
            end else begin
                start = 1'b0;
            end
            if (addr_valid && rdy) begin
                chk(addr_out == m, tag, addr_out, m);
                le_exp = (e == ne_eff - 1);
                lb_exp = le_exp && (f == nf_eff - 1);
                chk(last_elem == le_exp, "R6", {31'b0, last_elem}, {31'b0, le_exp});
                chk(last_block == lb_exp, lt, {31'b0, last_block}, {31'b0, lb_exp});
                if (le_exp) begin
                    m = v.dbl ? m + es - 32'd1 + v.fi : m + es;
                    tag = v.dbl ? "R4" : "R5 R1";
                    e = 0; f++;
                end else begin
                    m = v.dbl ? m + es - 32'd1 + {{16{v.ei[15]}}, v.ei} : m + es;
                    tag = v.dbl ? "R3 R1" : "R5 R1";
                    e++;
                end
                if (v.poke && k > 2) tag = {tag, " R9"};
                k++;
                hold_v = 1'b0;
            end else begin
                hold_v = addr_valid;
                hold_a = addr_out;
            end
            cyc++;
            @(negedge clk);
        end
        addr_ready = 1'b0; start = 1'b0;
        chk(k == beats, "R7 beat count", k, beats);
        chk(!busy && !addr_valid, lt, {30'b0, busy, addr_valid}, 32'h0);
        if (v.poke) chk(!busy, "R9 no late start", {31'b0, busy}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; start_addr = '0; size_code = '0; dbl_mode = 1'b0;
        elem_count = '0; frame_count = '0; elem_step = '0; frame_step = '0; addr_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !addr_valid, "R11 reset", {30'b0, busy, addr_valid}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !addr_valid, "R11 idle", {30'b0, busy, addr_valid}, 32'h0);

        for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

        // reset in the middle of a block
        @(negedge clk);
        start = 1'b1; start_addr = 32'h0000_7000; size_code = 2'd2; dbl_mode = 1'b0;
        elem_count = 16'd8; frame_count = 16'd8;
        @(negedge clk);
        start = 1'b0; addr_ready = 1'b1;
        @(negedge clk);
        chk(busy && addr_out == 32'h0000_7004, "R5 R1 pre-reset", addr_out, 32'h0000_7004);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; addr_ready = 1'b0;
        chk(!busy && !addr_valid, "R11 mid-block", {30'b0, busy, addr_valid}, 32'h0);

        // restart after reset begins at the new base
        start = 1'b1; start_addr = 32'h0000_8000;
        @(negedge clk);
        start = 1'b0;
        chk(addr_valid && addr_out == 32'h0000_8000, "R2 restart", addr_out, 32'h0000_8000);
        repeat (2) @(negedge clk);
        chk(addr_out == 32'h0000_8000, "R8 idle ready", addr_out, 32'h0000_8000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule